// File: doc/BRIEF.md
# Dual Page-Size Translation Lookaside Buffer

This block caches virtual-to-physical translations for a 32-bit virtual address space that maps onto a 28-bit physical space. Two page sizes are supported at once. Small pages are 4 KB and large pages are 2 MB. Each size has its own 4-way set-associative array. The small array has 16 sets and the large array has 8 sets. Every lookup searches both arrays in the same cycle. The untranslated low bits of the address pass straight through to the physical address.

A lookup is a valid strobe plus a virtual address. One clock later the block returns a registered response: hit, the physical address, which page size matched, and a flag raised when both arrays matched. When neither array matches, the block reports a miss and does nothing else. An external walker then resolves the translation and writes it back through the fill port, choosing the page size for the new entry. A flush input drops every cached translation in one cycle.

Top module: `dual_page_tlb`

## Requirements
- R1: After reset, every response output is 0 and every lookup misses until a fill has been made.
- R2: A 4 KB entry uses virtual page number vaddr[31:12] as its tag, and set vaddr[15:12]. On a hit the physical address is {stored 16-bit frame, vaddr[11:0]} and rsp_big is 0.
- R3: A 2 MB entry uses virtual page number vaddr[31:21] as its tag, and set vaddr[23:21]. Only fill_pfn[6:0] is stored, so fill_pfn[15:7] has no effect. On a hit the physical address is {stored 7-bit frame, vaddr[20:0]} and rsp_big is 1.
- R4: The response registers the lookup sampled at the previous clock edge, and rsp_valid equals that lk_valid. When rsp_valid is 0, or on a miss, rsp_hit, rsp_big, rsp_multi and rsp_paddr are all 0.
- R5: A fill sampled at one edge is seen by lookups sampled from the next edge on. A lookup sampled at the same edge as the fill does not see it.
- R6: A lookup whose page number is in neither array returns rsp_valid=1 and rsp_hit=0.
- R7: A fill writes the lowest-numbered invalid way of its set. When all 4 ways are valid, it writes the way chosen by that set's 2-bit pointer, and the pointer then advances by one, wrapping at 4. Pointers are 0 after reset.
- R8: A fill whose page number is already held in its set overwrites that way. It takes no new way and leaves the pointer unchanged, so no page number is ever held twice in one set.
- R9: When both arrays hit, the 2 MB result is returned, with rsp_big=1 and rsp_multi=1.
- R10: A flush clears every entry and every pointer in both arrays in one cycle. A fill in the same cycle as a flush is dropped. A lookup in the same cycle as a flush still sees the old contents.
- R11: Fills to one set never evict or change entries of another set, and fills to one array never change the other array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all translations |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vaddr | input | 32 | Lookup virtual address |
| fill_en | input | 1 | Write a translation |
| fill_big | input | 1 | 1: 2 MB entry, 0: 4 KB entry |
| fill_vaddr | input | 32 | Virtual address of the page being filled |
| fill_pfn | input | 16 | Physical frame number; low 7 bits used for 2 MB |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | Translation found |
| rsp_big | output | 1 | Matching entry is a 2 MB page |
| rsp_multi | output | 1 | Both arrays matched |
| rsp_paddr | output | 28 | Physical address |

## Verification
If a valid bit, tag or frame is corrupted, the next lookup of that page shows it one cycle later, as a wrong hit, miss or physical address. A wrong replacement pointer or a wrong invalid-first choice stays hidden until a fifth distinct page enters a full set. After that, one of the earlier pages misses when it should hit, or hits when it should have been evicted. A flush that leaves a bit behind shows as a hit on the first lookup after the flush. The bench runs a behavioural model with its own per-set replacement state. It compares every response against that model, using random traffic that is dense in a few sets so evictions happen often.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int VA_W      = 32;
  parameter int PA_W      = 28;
  parameter int SM_OFF_W  = 12;
  parameter int BG_OFF_W  = 21;
  parameter int SM_SETS   = 16;
  parameter int BG_SETS   = 8;
  parameter int TLB_WAYS  = 4;

  localparam int SM_VPN_W = VA_W - SM_OFF_W;
  localparam int SM_PFN_W = PA_W - SM_OFF_W;
  localparam int BG_VPN_W = VA_W - BG_OFF_W;
  localparam int BG_PFN_W = PA_W - BG_OFF_W;

  typedef struct packed {
    logic            valid;
    logic            hit;
    logic            big;
    logic            multi;
    logic [PA_W-1:0] paddr;
  } tlb_rsp_t;
endpackage

// File: rtl/tlb_way_pick.sv
module tlb_way_pick #(
  parameter int WAYS = 4,
  localparam int PW  = $clog2(WAYS)
) (
  input  logic [WAYS-1:0] valid_row,
  input  logic [WAYS-1:0] match_row,
  input  logic [PW-1:0]   ptr,
  output logic [PW-1:0]   way,
  output logic            advance
);
  logic [PW-1:0] inv_way, hit_way;
  logic          any_inv, any_hit;

  always_comb begin
    inv_way = '0;
    hit_way = '0;
    any_inv = 1'b0;
    any_hit = 1'b0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid_row[i]) begin
        inv_way = PW'(i);
        any_inv = 1'b1;
      end
      if (match_row[i]) begin
        hit_way = PW'(i);
        any_hit = 1'b1;
      end
    end
    if (any_hit) begin
      way     = hit_way;
      advance = 1'b0;
    end else if (any_inv) begin
      way     = inv_way;
      advance = 1'b0;
    end else begin
      way     = ptr;
      advance = 1'b1;
    end
  end
endmodule

// File: rtl/tlb_set_array.sv
module tlb_set_array #(
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int VPN_W = 20,
  parameter int PFN_W = 16,
  localparam int IDX_W = $clog2(SETS),
  localparam int PW    = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  input  logic             fl_en,
  input  logic [VPN_W-1:0] fl_vpn,
  input  logic [PFN_W-1:0] fl_pfn
);
  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAYS-1:0]  vld_d [SETS];
  logic [PW-1:0]    ptr_q [SETS];
  logic [PW-1:0]    ptr_d [SETS];
  logic [VPN_W-1:0] tag_q [SETS][WAYS];
  logic [PFN_W-1:0] pfn_q [SETS][WAYS];

  logic [IDX_W-1:0] lk_set, fl_set;
  logic [WAYS-1:0]  lk_match, fl_match;
  logic [PW-1:0]    fl_way;
  logic             fl_adv, wr;

  assign lk_set = lk_vpn[IDX_W-1:0];
  assign fl_set = fl_vpn[IDX_W-1:0];
  assign wr     = fl_en && !flush;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign lk_match[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_vpn);
    assign fl_match[w] = vld_q[fl_set][w] && (tag_q[fl_set][w] == fl_vpn);
  end

  always_comb begin
    lk_pfn = '0;
    for (int w = 0; w < WAYS; w++)
      if (lk_match[w]) lk_pfn = lk_pfn | pfn_q[lk_set][w];
  end
  assign lk_hit = |lk_match;

  tlb_way_pick #(.WAYS(WAYS)) u_pick (
    .valid_row (vld_q[fl_set]),
    .match_row (fl_match),
    .ptr       (ptr_q[fl_set]),
    .way       (fl_way),
    .advance   (fl_adv)
  );

  // next state of valid bits and replacement pointers
  always_comb begin
    vld_d = vld_q;
    ptr_d = ptr_q;
    if (flush) begin
      for (int s = 0; s < SETS; s++) begin
        vld_d[s] = '0;
        ptr_d[s] = '0;
      end
    end else if (wr) begin
      vld_d[fl_set][fl_way] = 1'b1;
      if (fl_adv) ptr_d[fl_set] = ptr_q[fl_set] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        ptr_q[s] <= '0;
      end
    end else begin
      vld_q <= vld_d;
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr) begin
      tag_q[fl_set][fl_way] <= fl_vpn;
      pfn_q[fl_set][fl_way] <= fl_pfn;
    end
  end

  // R8
  lk_single_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  // R7
  ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (&vld_q[fl_set]) && !(|fl_match)) |=>
      (ptr_q[$past(fl_set)] == PW'($past(ptr_q[fl_set]) + 1'b1)));

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> !lk_hit);
endmodule

// File: rtl/dual_page_tlb.sv
module dual_page_tlb
  import tlb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                lk_valid,
  input  logic [VA_W-1:0]     lk_vaddr,
  input  logic                fill_en,
  input  logic                fill_big,
  input  logic [VA_W-1:0]     fill_vaddr,
  input  logic [SM_PFN_W-1:0] fill_pfn,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic                rsp_big,
  output logic                rsp_multi,
  output logic [PA_W-1:0]     rsp_paddr
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic                sm_hit, bg_hit;
  logic [SM_PFN_W-1:0] sm_pfn;
  logic [BG_PFN_W-1:0] bg_pfn;

  tlb_set_array #(
    .WAYS(TLB_WAYS), .SETS(SM_SETS), .VPN_W(SM_VPN_W), .PFN_W(SM_PFN_W)
  ) u_small (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .flush  (flush),
    .lk_vpn (lk_vaddr[VA_W-1:SM_OFF_W]),
    .lk_hit (sm_hit),
    .lk_pfn (sm_pfn),
    .fl_en  (fill_en && !fill_big),
    .fl_vpn (fill_vaddr[VA_W-1:SM_OFF_W]),
    .fl_pfn (fill_pfn)
  );

  tlb_set_array #(
    .WAYS(TLB_WAYS), .SETS(BG_SETS), .VPN_W(BG_VPN_W), .PFN_W(BG_PFN_W)
  ) u_big (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .flush  (flush),
    .lk_vpn (lk_vaddr[VA_W-1:BG_OFF_W]),
    .lk_hit (bg_hit),
    .lk_pfn (bg_pfn),
    .fl_en  (fill_en && fill_big),
    .fl_vpn (fill_vaddr[VA_W-1:BG_OFF_W]),
    .fl_pfn (fill_pfn[BG_PFN_W-1:0])
  );

  tlb_rsp_t rsp_d, rsp_q;

  always_comb begin
    rsp_d       = '0;
    rsp_d.valid = lk_valid;
    if (lk_valid) begin
      rsp_d.hit   = sm_hit || bg_hit;
      rsp_d.big   = bg_hit;
      rsp_d.multi = sm_hit && bg_hit;
      if (bg_hit)      rsp_d.paddr = {bg_pfn, lk_vaddr[BG_OFF_W-1:0]};
      else if (sm_hit) rsp_d.paddr = {sm_pfn, lk_vaddr[SM_OFF_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) rsp_q <= '0;
    else          rsp_q <= rsp_d;
  end

  assign rsp_valid = rsp_q.valid;
  assign rsp_hit   = rsp_q.hit;
  assign rsp_big   = rsp_q.big;
  assign rsp_multi = rsp_q.multi;
  assign rsp_paddr = rsp_q.paddr;

  // R4
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rsp_hit || rsp_big || rsp_multi) |-> rsp_valid);

  // R4
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(rst_n_s) |-> (rsp_valid == $past(lk_valid)));

  // R9
  multi_prio_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    rsp_multi |-> (rsp_hit && rsp_big));

  // R2
  small_offset_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rsp_hit && !rsp_big) |-> (rsp_paddr[SM_OFF_W-1:0] == $past(lk_vaddr[SM_OFF_W-1:0])));

  // R3
  big_offset_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rsp_hit && rsp_big) |-> (rsp_paddr[BG_OFF_W-1:0] == $past(lk_vaddr[BG_OFF_W-1:0])));
endmodule

// File: tb/dual_page_tlb_tb.sv
module dual_page_tlb_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        fill_en = 1'b0;
  logic        fill_big = 1'b0;
  logic [31:0] fill_vaddr = '0;
  logic [15:0] fill_pfn = '0;
  logic        rsp_valid, rsp_hit, rsp_big, rsp_multi;
  logic [27:0] rsp_paddr;

  always #2 clk = ~clk;

  dual_page_tlb dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .fill_en(fill_en), .fill_big(fill_big), .fill_vaddr(fill_vaddr), .fill_pfn(fill_pfn),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_big(rsp_big),
    .rsp_multi(rsp_multi), .rsp_paddr(rsp_paddr)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference state
  bit          sv [16][4];
  int unsigned st [16][4];
  int unsigned sp [16][4];
  int          sptr [16];
  bit          bv [8][4];
  int unsigned bt [8][4];
  int unsigned bp [8][4];
  int          bptr [8];

  bit          e_valid, e_hit, e_big, e_multi;
  logic [27:0] e_paddr;

  task automatic model_clear();
    for (int s = 0; s < 16; s++) begin
      sptr[s] = 0;
      for (int w = 0; w < 4; w++) sv[s][w] = 0;
    end
    for (int s = 0; s < 8; s++) begin
      bptr[s] = 0;
      for (int w = 0; w < 4; w++) bv[s][w] = 0;
    end
  endtask

  task automatic model_cycle();
    bit sh, bh;
    int unsigned spf, bpf;
    int s, tag, way;
    sh = 0; bh = 0; spf = 0; bpf = 0;
    if (lk_valid) begin
      s = int'(lk_vaddr[15:12]);
      for (int w = 0; w < 4; w++)
        if (sv[s][w] && st[s][w] == lk_vaddr[31:12]) begin sh = 1; spf = sp[s][w]; end
      s = int'(lk_vaddr[23:21]);
      for (int w = 0; w < 4; w++)
        if (bv[s][w] && bt[s][w] == lk_vaddr[31:21]) begin bh = 1; bpf = bp[s][w]; end
    end
    e_valid = lk_valid;
    e_hit   = sh | bh;
    e_big   = bh;
    e_multi = sh & bh;
    if (bh)      e_paddr = {bpf[6:0], lk_vaddr[20:0]};
    else if (sh) e_paddr = {spf[15:0], lk_vaddr[11:0]};
    else         e_paddr = '0;
    if (flush) model_clear();
    else if (fill_en && !fill_big) begin
      s = int'(fill_vaddr[15:12]); tag = int'(fill_vaddr[31:12]); way = -1;
      for (int w = 0; w < 4; w++) if (sv[s][w] && st[s][w] == tag) way = w;
      if (way < 0) for (int w = 3; w >= 0; w--) if (!sv[s][w]) way = w;
      if (way < 0) begin way = sptr[s]; sptr[s] = (sptr[s] + 1) % 4; end
      sv[s][way] = 1; st[s][way] = tag; sp[s][way] = fill_pfn;
    end else if (fill_en && fill_big) begin
      s = int'(fill_vaddr[23:21]); tag = int'(fill_vaddr[31:21]); way = -1;
      for (int w = 0; w < 4; w++) if (bv[s][w] && bt[s][w] == tag) way = w;
      if (way < 0) for (int w = 3; w >= 0; w--) if (!bv[s][w]) way = w;
      if (way < 0) begin way = bptr[s]; bptr[s] = (bptr[s] + 1) % 4; end
      bv[s][way] = 1; bt[s][way] = tag; bp[s][way] = fill_pfn[6:0];
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    chk(rsp_valid == e_valid, req, "rsp_valid", 32'(rsp_valid), 32'(e_valid));
    chk(rsp_hit   == e_hit,   req, "rsp_hit",   32'(rsp_hit),   32'(e_hit));
    chk(rsp_big   == e_big,   req, "rsp_big",   32'(rsp_big),   32'(e_big));
    chk(rsp_multi == e_multi, req, "rsp_multi", 32'(rsp_multi), 32'(e_multi));
    chk(rsp_paddr == e_paddr, req, "rsp_paddr", 32'(rsp_paddr), 32'(e_paddr));
  endtask

  task automatic step(input string req);
    @(posedge clk);
    model_cycle();
    @(negedge clk);
    compare(req);
  endtask

  task automatic idle();
    lk_valid = 0; fill_en = 0; flush = 0;
  endtask

  task automatic look(input logic [31:0] va);
    lk_valid = 1; lk_vaddr = va;
  endtask

  task automatic fill(input bit big, input logic [31:0] va, input logic [15:0] pfn);
    fill_en = 1; fill_big = big; fill_vaddr = va; fill_pfn = pfn;
  endtask

  task automatic expect_now(input string req, input bit hit, input bit big,
                            input logic [27:0] pa);
    chk(rsp_hit == hit, req, "directed hit", 32'(rsp_hit), 32'(hit));
    if (hit) begin
      chk(rsp_big == big, req, "directed big", 32'(rsp_big), 32'(big));
      chk(rsp_paddr == pa, req, "directed paddr", 32'(rsp_paddr), 32'(pa));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] va;
    model_clear();
    e_valid = 0; e_hit = 0; e_big = 0; e_multi = 0; e_paddr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1: reset state
    compare("R1");
    look(32'h1234_5678); step("R1");
    expect_now("R1", 0, 0, '0);
    // R5: fill and lookup same cycle misses
    idle(); fill(0, 32'h1234_5000, 16'hABCD); look(32'h1234_5678); step("R5");
    idle(); look(32'h1234_5678); step("R5");
    // R2: small page translation
    expect_now("R2", 1, 0, 28'hABC_D678);
    // R6: a miss on an unknown page
    idle(); look(32'h1234_6000); step("R6");
    // R4: no lookup gives zero outputs
    idle(); step("R4");
    // R3: big page, upper pfn bits ignored
    fill(1, 32'h4020_0000, 16'hFF55); step("R3");
    idle(); look(32'h403A_BCDE); step("R3");
    expect_now("R3", 1, 1, {7'h55, 21'h1A_BCDE});
    // R9: both arrays hit
    idle(); fill(0, 32'h4020_1000, 16'h1111); step("R9");
    idle(); look(32'h4020_1234); step("R9");
    chk(rsp_multi == 1'b1, "R9", "multi", 32'(rsp_multi), 32'd1);
    // R7: six distinct pages into small set 3
    for (int i = 0; i < 6; i++) begin
      idle(); fill(0, {12'h700 + 12'(i), 4'h0, 4'h3, 12'h000}, 16'(16'h0200 + i)); step("R7");
    end
    // R11: a fill to set 4 leaves set 3 unchanged
    idle(); fill(0, 32'h7774_4000, 16'h0444); step("R11");
    for (int i = 0; i < 6; i++) begin
      idle(); look({12'h700 + 12'(i), 4'h0, 4'h3, 12'h0AB}); step("R7");
    end
    // R8: refill same page updates its frame
    idle(); fill(0, {12'h705, 4'h0, 4'h3, 12'h000}, 16'h0999); step("R8");
    idle(); look({12'h705, 4'h0, 4'h3, 12'h001}); step("R8");
    expect_now("R8", 1, 0, 28'h099_9001);
    // R10: flush with fill in same cycle, lookup sees old content
    idle(); flush = 1; fill(1, 32'h6000_0000, 16'h0012); look(32'h1234_5678); step("R10");
    expect_now("R10", 1, 0, 28'hABC_D678);
    idle(); look(32'h1234_5678); step("R10");
    idle(); look(32'h6000_0000); step("R10");
    // random traffic, concentrated on a few sets
    for (int n = 0; n < 3000; n++) begin
      idle();
      va = $urandom;
      va[31:26] = 6'h21;
      va[25:24] = 2'($urandom_range(0, 3));
      va[23:21] = 3'($urandom_range(0, 1));
      va[20:16] = 5'($urandom_range(0, 1));
      va[15:13] = 3'b000;
      if ($urandom_range(0, 2) == 0) fill($urandom_range(0, 1) == 1, va, 16'($urandom));
      va[25:24] = 2'($urandom_range(0, 3));
      va[20:16] = 5'($urandom_range(0, 1));
      if ($urandom_range(0, 3) != 0) look(va);
      if ($urandom_range(0, 400) == 0) flush = 1;
      step("R7");
    end
    idle(); step("R4");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule